// File: doc/BRIEF.md
# Time-Triggered Bus Cycle Synchronizer

This block keeps the time base of a node on a time-triggered, CAN-style bus. A free-running local time counter advances on a tick-enable input. Every start of frame seen on the bus is recorded as a tentative sync capture. The capture becomes the origin of the bus cycle only when the frame ends and is confirmed to be a valid reference message.

The cycle time output is the distance from that origin to the current local time. Schedulers downstream compare it against their time marks. Frame decoding, bit timing and drift correction are done elsewhere. This block only needs the start-of-frame pulse, the end-of-frame pulse, and the validity flag that comes with the end-of-frame pulse.

Top module: `tt_cycle_sync`

## Requirements
- R1: After reset, local time, sync mark, reference mark and cycle time are all zero, and ref_loaded_o is low.
- R2: Local time is a 16-bit counter. It rises by exactly one on each clock where tick_en_i is high, holds otherwise, and wraps from 0xFFFF to 0x0000.
- R3: On a clock with sof_i high, the local time present in that cycle is stored as the sync mark, which is visible from the next cycle.
- R4: A second start of frame before the frame completes overwrites the sync mark. Without sof_i the sync mark holds.
- R5: On a clock with eof_i and ref_valid_i both high, the reference mark takes the sync mark value held in that cycle, visible from the next cycle.
- R6: When eof_i is high and ref_valid_i is low, the reference mark is unchanged and no load pulse appears. ref_valid_i has no effect without eof_i.
- R7: cycle_time_o always equals local_time_o minus ref_mark_o modulo 2^16, with no added latency, so it stays correct across counter wraparound.
- R8: ref_loaded_o is high for exactly the one cycle in which the new reference mark first appears, and low otherwise.
- R9: When sof_i and eof_i with ref_valid_i arrive in the same cycle, the reference mark takes the previous sync mark and the sync mark takes the current local time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Advance local time by one this cycle |
| sof_i | input | 1 | Start-of-frame detected on the bus |
| eof_i | input | 1 | Frame fully received |
| ref_valid_i | input | 1 | Completed frame is a valid reference message (qualified by eof_i) |
| local_time_o | output | 16 | Current local time |
| sync_mark_o | output | 16 | Local time at the last start of frame |
| ref_mark_o | output | 16 | Current cycle origin |
| cycle_time_o | output | 16 | Local time minus reference mark |
| ref_loaded_o | output | 1 | One-cycle pulse when the reference mark changes |

## Verification
The assertions assume nothing about frame ordering. An end of frame may occur with no preceding start, two starts may occur back to back, and all pulses may coincide. They only take the inputs as sampled at the rising edge. The stimulus therefore mixes directed sequences with unconstrained random pulses, and includes a full pass of the counter through its wrap. The behavioural model follows every legal and illegal ordering.

// File: rtl/tt_sync_pkg.sv
package tt_sync_pkg;
  localparam int unsigned TIME_W = 16;
  typedef logic [TIME_W-1:0] time_t;
endpackage

// File: rtl/tt_local_timer.sv
module tt_local_timer
  import tt_sync_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_en_i,
  output time_t time_o
);
  time_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (tick_en_i) cnt_q <= cnt_q + time_t'(1);
  end

  assign time_o = cnt_q;
endmodule

// File: rtl/tt_mark_capture.sv
module tt_mark_capture
  import tt_sync_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  time_t now_i,
  input  logic  sof_i,
  input  logic  eof_i,
  input  logic  ref_valid_i,
  output time_t sync_mark_o,
  output time_t ref_mark_o,
  output logic  ref_loaded_o
);
  time_t sync_q, ref_q;
  logic  load_q;
  logic  accept;

  assign accept = eof_i & ref_valid_i;

  // tentative capture; always overwritten by the latest start of frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sync_q <= '0;
    else if (sof_i) sync_q <= now_i;
  end

  // commit uses the capture held before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= accept;
      if (accept) ref_q <= sync_q;
    end
  end

  assign sync_mark_o  = sync_q;
  assign ref_mark_o   = ref_q;
  assign ref_loaded_o = load_q;
endmodule

// File: rtl/tt_cycle_calc.sv
module tt_cycle_calc
  import tt_sync_pkg::*;
(
  input  time_t now_i,
  input  time_t origin_i,
  output time_t cycle_o
);
  // modulo subtraction; wrap handled by width truncation
  assign cycle_o = now_i - origin_i;
endmodule

// File: rtl/tt_cycle_sync.sv
module tt_cycle_sync
  import tt_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              ref_valid_i,
  output logic [TIME_W-1:0] local_time_o,
  output logic [TIME_W-1:0] sync_mark_o,
  output logic [TIME_W-1:0] ref_mark_o,
  output logic [TIME_W-1:0] cycle_time_o,
  output logic              ref_loaded_o
);
  time_t now, sync_mark, ref_mark, cycle;

  tt_local_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .time_o    (now)
  );

  tt_mark_capture u_marks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .now_i        (now),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .ref_valid_i  (ref_valid_i),
    .sync_mark_o  (sync_mark),
    .ref_mark_o   (ref_mark),
    .ref_loaded_o (ref_loaded_o)
  );

  tt_cycle_calc u_cycle (
    .now_i    (now),
    .origin_i (ref_mark),
    .cycle_o  (cycle)
  );

  assign local_time_o = now;
  assign sync_mark_o  = sync_mark;
  assign ref_mark_o   = ref_mark;
  assign cycle_time_o = cycle;
endmodule

// File: rtl/tt_cycle_sync_chk.sv
module tt_cycle_sync_chk
  import tt_sync_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  tick_en_i,
  input logic  sof_i,
  input logic  eof_i,
  input logic  ref_valid_i,
  input time_t local_time_o,
  input time_t sync_mark_o,
  input time_t ref_mark_o,
  input time_t cycle_time_o,
  input logic  ref_loaded_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (local_time_o == '0 && ref_mark_o == '0 && !ref_loaded_o)) else $error("reset"); // R1
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && tick_en_i) |=> local_time_o == $past(local_time_o) + time_t'(1)) else $error("tick"); // R2
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tick_en_i) |=> $stable(local_time_o)) else $error("hold"); // R2
  AST_SYNC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sof_i) |=> sync_mark_o == $past(local_time_o)) else $error("sync"); // R3
  AST_SYNC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !sof_i) |=> $stable(sync_mark_o)) else $error("sync hold"); // R4
  AST_REF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && eof_i && ref_valid_i) |=> (ref_mark_o == $past(sync_mark_o) && ref_loaded_o)) else $error("load"); // R5
  AST_REF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !(eof_i && ref_valid_i)) |=> ($stable(ref_mark_o) && !ref_loaded_o)) else $error("keep"); // R6
  AST_CYCLE_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_time_o + ref_mark_o == local_time_o) else $error("cycle"); // R7
endmodule

bind tt_cycle_sync tt_cycle_sync_chk u_chk (.*);

// File: tb/tt_cycle_sync_test.sv
module tt_cycle_sync_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, sof = 0, eof = 0, ref_valid = 0;
  logic [15:0] local_time, sync_mark, ref_mark, cycle_time;
  logic ref_loaded;

  int checks = 0, fails = 0;
  int m_local = 0, m_sync = 0, m_ref = 0;
  bit m_pulse = 0;
  int pulses[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_cycle_sync uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .sof_i(sof), .eof_i(eof),
    .ref_valid_i(ref_valid), .local_time_o(local_time), .sync_mark_o(sync_mark),
    .ref_mark_o(ref_mark), .cycle_time_o(cycle_time), .ref_loaded_o(ref_loaded)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 local", local_time, m_local);
    chk("R3 sync", sync_mark, m_sync);
    chk("R5 ref", ref_mark, m_ref);
    chk("R7 cycle", cycle_time, (m_local - m_ref) & 16'hFFFF);
    chk("R8 pulse", ref_loaded, m_pulse);
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic step(bit t, bit s, bit e, bit v);
    int old_sync;
    tick_en = t; sof = s; eof = e; ref_valid = v;
    @(posedge clk);
    old_sync = m_sync;
    if (s) m_sync = m_local;
    m_pulse = e && v;
    if (e && v) m_ref = old_sync;
    if (t) m_local = (m_local + 1) & 16'hFFFF;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1 local", local_time, 0); chk("R1 sync", sync_mark, 0);
    chk("R1 ref", ref_mark, 0); chk("R1 cycle", cycle_time, 0); chk("R1 pulse", ref_loaded, 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (5) step(1, 0, 0, 0);
    step(0, 0, 0, 0);                     // R2 hold
    step(1, 1, 0, 0);                     // R3 capture 5
    chk("R3 captured", sync_mark, 5);
    repeat (3) step(1, 0, 0, 0);
    step(1, 1, 0, 0);                     // R4 overwrite with 9
    chk("R4 overwrite", sync_mark, 9);
    step(1, 0, 1, 0);                     // R6 not a reference
    chk("R6 ref kept", ref_mark, 0); chk("R6 no pulse", ref_loaded, 0);
    step(1, 0, 0, 1);                     // R6 valid without eof
    chk("R6 valid alone", ref_mark, 0);
    step(1, 0, 1, 1);                     // R5 commit 9
    chk("R5 ref loaded", ref_mark, 9); chk("R8 pulse high", ref_loaded, 1);
    step(1, 0, 0, 0);
    chk("R8 pulse single", ref_loaded, 0);
    step(1, 1, 1, 1);                     // R9 simultaneous
    chk("R9 ref old sync", ref_mark, 9); chk("R9 new sync", sync_mark, m_local - 1);
    // R7 across wrap: long run
    for (int i = 0; i < 65540; i++) step(1, (i == 65000), (i == 65010), 1'b1);
    chk("R7 wrapped cycle", cycle_time, (m_local - m_ref) & 16'hFFFF);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0), $urandom_range(0, 1));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule